// File: doc/BRIEF.md
# SPI Transfer-Group Sequencer

This block steps through a shared buffer RAM of SPI words, one transfer group at a time. Software or DMA loads transmit words and a small per-buffer mode into the RAM. Each group is a window of buffer indices, given by a first and a last index. A trigger pulse arms the group. The sequencer then takes the buffers of the group in index order. It hands each transmit word to an external shift engine and writes the returned receive word back into the same buffer. It keeps a transmit-full and a receive-full status bit for every buffer.

A buffer's mode can hold the sequence at that buffer. The hold lasts until fresh transmit data has been written to the buffer, until its old receive word has been read, or until both have happened. While the group is held, the block raises a per-group suspend flag and can request DMA service. When the last buffer of a group has been exchanged, the block raises a per-group completion flag. An interrupt vector register reports the most urgent pending flag and clears it when read. Two groups can be armed in turn, so that one group is refilled while the other is being shifted.

Top module: `spi_tg_seq`

## Requirements
- R1: After reset the interrupt output, the shift request and all DMA requests are low, and the flags register and the vector register both read 0.
- R2: A triggered group offers its buffers from the first index to the last index inclusive, in increasing index order, one shift request per buffer, and holds the transmit word stable until the acknowledge. The returned word is stored in that buffer's receive slot. Exchanging a buffer sets its receive-full status (control word bit 9) and clears its transmit-full status (control word bit 8). Writing the transmit slot sets transmit-full, and reading the receive slot clears receive-full.
- R3: Mode 5 (control word bits 2:0) holds the group at that buffer while its transmit-full status is clear. Writing its transmit slot releases the hold.
- R4: Mode 6 holds the group at that buffer while its receive-full status is set. Reading its receive slot releases the hold.
- R5: Mode 7 holds the group until transmit-full is set and receive-full is clear. Either event on its own does not release the hold.
- R6: While a group is held, its suspend flag (flags register bit 8+g) is set. Reading the vector register clears the reported flag. If the hold still exists, the suspend flag is set again on the following cycle.
- R7: The completion flag of group g (flags register bit g) is set when the last buffer of that group has been exchanged.
- R8: The vector register reads 0 when no flag is pending. Otherwise it reads g+1 for a completion flag of group g, or 0x10 + g+1 for a suspend flag of group g. Any suspend flag takes priority over any completion flag, and a lower group number takes priority over a higher one.
- R9: Writing 1 to a bit of the flags register (register index 8) clears that flag. Writing 0 leaves it unchanged.
- R10: A transmit DMA request for group g is high only while g is held waiting for transmit data and bit g of the DMA register (index 10) is set. A receive DMA request is high only while g is held waiting for a receive read and bit 8+g of that register is set.
- R11: A trigger for a group that is still armed or running is ignored. The group is exchanged only once.
- R12: When several groups are armed, they run one after another, each to completion, with the lowest group number first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 2 | Access space: 0 transmit slot, 1 buffer control, 2 receive slot, 3 registers |
| bus_idx | input | IW | Buffer index, or register index when bus_sel is 3 (group g config at index g, first index in bits IW-1:0 and last index in bits 8+IW-1:8) |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; data appears on bus_rdata on the next cycle |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| grp_trig | input | NGRP | One-cycle trigger per group |
| sh_req | output | 1 | Shift engine request, held until acknowledged |
| sh_txd | output | DW | Word to shift out |
| sh_ack | input | 1 | Shift engine done with the current word |
| sh_rxd | input | DW | Word shifted in, valid with sh_ack |
| irq | output | 1 | High while any flag is pending |
| dma_tx_req | output | NGRP | Per-group request for transmit refill |
| dma_rx_req | output | NGRP | Per-group request for receive drain |

## Verification
The hardest state to reach is a group held on a buffer whose condition is only half met under mode 7. At the same time a completion flag of another group must be pending, so that the vector priority and the re-raising of the suspend flag after a vector read can both be seen. Directed runs build this state step by step. First the group is run once, so that the receive-full bits are left set. Then the buffer's mode is changed and the group is triggered again. The transmit slot is refilled before the receive slot is drained, and the number of words the shift-engine model has logged is checked after each step. Random windows with random data and random acknowledge latency then cover the ordinary flow.

// File: rtl/spi_tg_pkg.sv
// Shared encodings of the transfer-group sequencer: bus spaces, register
// indices, hold modes and engine states. Assumes DW >= 16 and NGRP <= 8.
package spi_tg_pkg;

    typedef enum logic [1:0] {
        SEL_TXD = 2'd0,
        SEL_CTL = 2'd1,
        SEL_RXD = 2'd2,
        SEL_REG = 2'd3
    } bus_sel_e;

    localparam int unsigned REG_FLAGS = 8;
    localparam int unsigned REG_VEC   = 9;
    localparam int unsigned REG_DMA   = 10;
    localparam int unsigned HI_OFS    = 8;

    localparam logic [2:0] MODE_HOLD_TX   = 3'd5;
    localparam logic [2:0] MODE_HOLD_RX   = 3'd6;
    localparam logic [2:0] MODE_HOLD_BOTH = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_SHIFT = 2'd2
    } eng_state_e;

endpackage

// File: rtl/spi_tg_bufram.sv
// Buffer RAM: per-entry transmit word, receive word, hold mode and the two
// status bits. One port serves the register bus, the other the sequencer.
// Assumes at most one bus access per cycle. Data words are not reset.
module spi_tg_bufram #(
    parameter int unsigned NBUF = 128,
    parameter int unsigned DW   = 16,
    localparam int unsigned IW  = $clog2(NBUF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_txd_we,
    input  logic          bus_ctl_we,
    input  logic          bus_rxd_re,
    input  logic [IW-1:0] bus_idx,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_txd_q,
    output logic [DW-1:0] bus_rxd_q,
    output logic [2:0]    bus_mode_q,
    output logic          bus_txf_q,
    output logic          bus_rxf_q,
    input  logic [IW-1:0] eng_idx,
    input  logic          eng_wr,
    input  logic [DW-1:0] eng_rxd,
    output logic [DW-1:0] eng_txd,
    output logic [2:0]    eng_mode,
    output logic          eng_txf,
    output logic          eng_rxf
);
    logic [DW-1:0] txd_mem [NBUF];
    logic [DW-1:0] rxd_mem [NBUF];
    logic [2:0]    mode_mem [NBUF];
    logic [NBUF-1:0] txf;
    logic [NBUF-1:0] rxf;

    // data words: bus writes transmit slots, sequencer writes receive slots
    always_ff @(posedge clk) begin
        if (bus_txd_we) txd_mem[bus_idx] <= bus_wdata;
        if (eng_wr)     rxd_mem[eng_idx] <= eng_rxd;
    end

    // modes and status; a sequencer fill beats a same-cycle drain, a bus fill beats a consume
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_mem <= '{default: '0};
            txf      <= '0;
            rxf      <= '0;
        end else begin
            if (bus_ctl_we) mode_mem[bus_idx] <= bus_wdata[2:0];
            if (bus_rxd_re) rxf[bus_idx] <= 1'b0;
            if (eng_wr) begin
                txf[eng_idx] <= 1'b0;
                rxf[eng_idx] <= 1'b1;
            end
            if (bus_txd_we) txf[bus_idx] <= 1'b1;
        end
    end

    // combinational read views for both ports
    always_comb begin
        bus_txd_q  = txd_mem[bus_idx];
        bus_rxd_q  = rxd_mem[bus_idx];
        bus_mode_q = mode_mem[bus_idx];
        bus_txf_q  = txf[bus_idx];
        bus_rxf_q  = rxf[bus_idx];
        eng_txd    = txd_mem[eng_idx];
        eng_mode   = mode_mem[eng_idx];
        eng_txf    = txf[eng_idx];
        eng_rxf    = rxf[eng_idx];
    end
endmodule

// File: rtl/spi_tg_engine.sv
// Sequencer core: arms groups on trigger, runs the lowest armed group from
// its first to its last buffer, evaluates each buffer's hold mode, and
// exchanges one word per buffer with the shift engine. Assumes NBUF is a
// power of two; an index range that wraps runs through the top of the RAM.
module spi_tg_engine
    import spi_tg_pkg::*;
#(
    parameter int unsigned NBUF = 128,
    parameter int unsigned DW   = 16,
    parameter int unsigned NGRP = 2,
    localparam int unsigned IW  = $clog2(NBUF),
    localparam int unsigned GW  = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NGRP-1:0]           trig,
    input  logic [NGRP-1:0][IW-1:0]   grp_first,
    input  logic [NGRP-1:0][IW-1:0]   grp_last,
    output logic [IW-1:0]             buf_idx,
    input  logic [2:0]                buf_mode,
    input  logic                      buf_txf,
    input  logic                      buf_rxf,
    input  logic [DW-1:0]             buf_txd,
    output logic                      buf_wr,
    output logic                      sh_req,
    output logic [DW-1:0]             sh_txd,
    input  logic                      sh_ack,
    output logic [NGRP-1:0]           set_susp,
    output logic [NGRP-1:0]           set_done,
    output logic [NGRP-1:0]           wait_tx,
    output logic [NGRP-1:0]           wait_rx
);
    eng_state_e      state;
    logic [IW-1:0]   ptr;
    logic [IW-1:0]   last_q;
    logic [GW-1:0]   grp;
    logic [GW-1:0]   pick;
    logic [NGRP-1:0] armed;
    logic [DW-1:0]   txd_q;
    logic            need_tx, need_rx, in_check, held, finish;

    // lowest armed group number wins
    always_comb begin
        pick = '0;
        for (int g = NGRP - 1; g >= 0; g--) begin
            if (armed[g]) pick = GW'(g);
        end
    end

    // hold evaluation for the buffer under the pointer
    always_comb begin
        need_tx  = ((buf_mode == MODE_HOLD_TX) || (buf_mode == MODE_HOLD_BOTH)) && !buf_txf;
        need_rx  = ((buf_mode == MODE_HOLD_RX) || (buf_mode == MODE_HOLD_BOTH)) && buf_rxf;
        in_check = (state == ST_CHECK);
        held     = in_check && (need_tx || need_rx);
        finish   = (state == ST_SHIFT) && sh_ack && (ptr == last_q);
    end

    // per-group decode of hold, suspend and completion events
    always_comb begin
        for (int g = 0; g < NGRP; g++) begin
            set_susp[g] = held && (grp == GW'(g));
            wait_tx[g]  = in_check && need_tx && (grp == GW'(g));
            wait_rx[g]  = in_check && need_rx && (grp == GW'(g));
            set_done[g] = finish && (grp == GW'(g));
        end
    end

    // arm on trigger; retrigger of an armed group has no effect; disarm on completion
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= '0;
        else        armed <= (armed | trig) & ~set_done;
    end

    // group walk: pick, check hold, shift, advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            last_q <= '0;
            grp    <= '0;
            txd_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (|armed) begin
                        grp    <= pick;
                        ptr    <= grp_first[pick];
                        last_q <= grp_last[pick];
                        state  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!(need_tx || need_rx)) begin
                        txd_q <= buf_txd;
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (sh_ack) begin
                        if (ptr == last_q) state <= ST_IDLE;
                        else begin
                            ptr   <= ptr + 1'b1;
                            state <= ST_CHECK;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs to shift engine and buffer RAM
    always_comb begin
        buf_idx = ptr;
        sh_req  = (state == ST_SHIFT);
        sh_txd  = txd_q;
        buf_wr  = (state == ST_SHIFT) && sh_ack;
    end
endmodule

// File: rtl/spi_tg_flags.sv
// Interrupt flags and vector: sticky per-group suspend and completion flags,
// write-one-to-clear, and a priority vector whose read clears the flag it
// reports. A suspend clear beats a same-cycle set (the hold sets it again
// next cycle); a completion set beats a same-cycle clear.
module spi_tg_flags #(
    parameter int unsigned NGRP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NGRP-1:0] set_susp,
    input  logic [NGRP-1:0] set_done,
    input  logic [NGRP-1:0] w1c_susp,
    input  logic [NGRP-1:0] w1c_done,
    input  logic            vec_rd,
    output logic [NGRP-1:0] susp_q,
    output logic [NGRP-1:0] done_q,
    output logic [7:0]      vec_code,
    output logic            irq
);
    logic [NGRP-1:0] pick_susp, pick_done;
    logic            hit;

    // priority encode: suspend first, lower group first
    always_comb begin
        vec_code  = '0;
        pick_susp = '0;
        pick_done = '0;
        hit       = 1'b0;
        for (int g = 0; g < NGRP; g++) begin
            if (!hit && susp_q[g]) begin
                hit          = 1'b1;
                pick_susp[g] = 1'b1;
                vec_code     = 8'h10 | 8'(g + 1);
            end
        end
        for (int g = 0; g < NGRP; g++) begin
            if (!hit && done_q[g]) begin
                hit          = 1'b1;
                pick_done[g] = 1'b1;
                vec_code     = 8'(g + 1);
            end
        end
    end

    // flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            susp_q <= '0;
            done_q <= '0;
        end else begin
            susp_q <= (susp_q | set_susp) & ~w1c_susp & ~(vec_rd ? pick_susp : '0);
            done_q <= (done_q & ~w1c_done & ~(vec_rd ? pick_done : '0)) | set_done;
        end
    end

    assign irq = (|susp_q) || (|done_q);
endmodule

// File: rtl/spi_tg_seq.sv
// Top of the transfer-group sequencer: register bus decode, group window
// and DMA enable registers, registered read data, and DMA request gating.
// Assumes one bus access (read or write) per cycle and IW <= 8.
module spi_tg_seq
    import spi_tg_pkg::*;
#(
    parameter int unsigned NBUF = 128,
    parameter int unsigned DW   = 16,
    parameter int unsigned NGRP = 2,
    localparam int unsigned IW  = $clog2(NBUF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      bus_sel,
    input  logic [IW-1:0]   bus_idx,
    input  logic            bus_we,
    input  logic            bus_re,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NGRP-1:0] grp_trig,
    output logic            sh_req,
    output logic [DW-1:0]   sh_txd,
    input  logic            sh_ack,
    input  logic [DW-1:0]   sh_rxd,
    output logic            irq,
    output logic [NGRP-1:0] dma_tx_req,
    output logic [NGRP-1:0] dma_rx_req
);
    bus_sel_e                  sel;
    logic                      is_reg, reg_we;
    logic                      txd_we, ctl_we, rxd_re, vec_rd;
    logic [NGRP-1:0][IW-1:0]   grp_first, grp_last;
    logic [NGRP-1:0]           dma_tx_en, dma_rx_en;
    logic [NGRP-1:0]           w1c_susp, w1c_done;
    logic [NGRP-1:0]           set_susp, set_done, wait_tx, wait_rx;
    logic [NGRP-1:0]           susp_q, done_q;
    logic [7:0]                vec_code;
    logic [DW-1:0]             b_txd, b_rxd, e_txd, reg_word, ctl_word;
    logic [2:0]                b_mode, e_mode;
    logic                      b_txf, b_rxf, e_txf, e_rxf, e_wr;
    logic [IW-1:0]             e_idx;

    // bus strobe decode
    always_comb begin
        sel      = bus_sel_e'(bus_sel);
        is_reg   = (sel == SEL_REG);
        reg_we   = bus_we && is_reg;
        txd_we   = bus_we && (sel == SEL_TXD);
        ctl_we   = bus_we && (sel == SEL_CTL);
        rxd_re   = bus_re && (sel == SEL_RXD);
        vec_rd   = bus_re && is_reg && (bus_idx == IW'(REG_VEC));
        w1c_done = (reg_we && bus_idx == IW'(REG_FLAGS)) ? bus_wdata[NGRP-1:0] : '0;
        w1c_susp = (reg_we && bus_idx == IW'(REG_FLAGS)) ? bus_wdata[HI_OFS +: NGRP] : '0;
    end

    // group windows and DMA enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_first <= '0;
            grp_last  <= '0;
            dma_tx_en <= '0;
            dma_rx_en <= '0;
        end else if (reg_we) begin
            for (int g = 0; g < NGRP; g++) begin
                if (bus_idx == IW'(g)) begin
                    grp_first[g] <= bus_wdata[IW-1:0];
                    grp_last[g]  <= bus_wdata[HI_OFS +: IW];
                end
            end
            if (bus_idx == IW'(REG_DMA)) begin
                dma_tx_en <= bus_wdata[NGRP-1:0];
                dma_rx_en <= bus_wdata[HI_OFS +: NGRP];
            end
        end
    end

    // register-space read view
    always_comb begin
        reg_word = '0;
        if (bus_idx == IW'(REG_FLAGS)) begin
            reg_word[NGRP-1:0]       = done_q;
            reg_word[HI_OFS +: NGRP] = susp_q;
        end else if (bus_idx == IW'(REG_VEC)) begin
            reg_word[7:0] = vec_code;
        end else if (bus_idx == IW'(REG_DMA)) begin
            reg_word[NGRP-1:0]       = dma_tx_en;
            reg_word[HI_OFS +: NGRP] = dma_rx_en;
        end else begin
            for (int g = 0; g < NGRP; g++) begin
                if (bus_idx == IW'(g)) begin
                    reg_word[IW-1:0]       = grp_first[g];
                    reg_word[HI_OFS +: IW] = grp_last[g];
                end
            end
        end
        ctl_word     = '0;
        ctl_word[2:0] = b_mode;
        ctl_word[8]   = b_txf;
        ctl_word[9]   = b_rxf;
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else if (bus_re) begin
            unique case (sel)
                SEL_TXD: bus_rdata <= b_txd;
                SEL_CTL: bus_rdata <= ctl_word;
                SEL_RXD: bus_rdata <= b_rxd;
                default: bus_rdata <= reg_word;
            endcase
        end
    end

    spi_tg_bufram #(.NBUF(NBUF), .DW(DW)) ram_i (
        .clk(clk), .rst_n(rst_n),
        .bus_txd_we(txd_we), .bus_ctl_we(ctl_we), .bus_rxd_re(rxd_re),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata),
        .bus_txd_q(b_txd), .bus_rxd_q(b_rxd), .bus_mode_q(b_mode),
        .bus_txf_q(b_txf), .bus_rxf_q(b_rxf),
        .eng_idx(e_idx), .eng_wr(e_wr), .eng_rxd(sh_rxd),
        .eng_txd(e_txd), .eng_mode(e_mode), .eng_txf(e_txf), .eng_rxf(e_rxf)
    );

    spi_tg_engine #(.NBUF(NBUF), .DW(DW), .NGRP(NGRP)) eng_i (
        .clk(clk), .rst_n(rst_n), .trig(grp_trig),
        .grp_first(grp_first), .grp_last(grp_last),
        .buf_idx(e_idx), .buf_mode(e_mode), .buf_txf(e_txf), .buf_rxf(e_rxf),
        .buf_txd(e_txd), .buf_wr(e_wr),
        .sh_req(sh_req), .sh_txd(sh_txd), .sh_ack(sh_ack),
        .set_susp(set_susp), .set_done(set_done),
        .wait_tx(wait_tx), .wait_rx(wait_rx)
    );

    spi_tg_flags #(.NGRP(NGRP)) flg_i (
        .clk(clk), .rst_n(rst_n),
        .set_susp(set_susp), .set_done(set_done),
        .w1c_susp(w1c_susp), .w1c_done(w1c_done), .vec_rd(vec_rd),
        .susp_q(susp_q), .done_q(done_q), .vec_code(vec_code), .irq(irq)
    );

    // DMA requests only for enabled groups
    assign dma_tx_req = wait_tx & dma_tx_en;
    assign dma_rx_req = wait_rx & dma_rx_en;
endmodule

// File: rtl/spi_tg_seq_chk.sv
// Temporal checks on the sequencer top, bound to every instance.
module spi_tg_seq_chk #(
    parameter int unsigned NGRP = 2,
    parameter int unsigned DW   = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sh_req,
    input logic            sh_ack,
    input logic [DW-1:0]   sh_txd,
    input logic [NGRP-1:0] dma_tx_req,
    input logic [NGRP-1:0] dma_rx_req,
    input logic [NGRP-1:0] dma_tx_en,
    input logic [NGRP-1:0] dma_rx_en,
    input logic [NGRP-1:0] done_q
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sh_req && !sh_ack |=> sh_req && $stable(sh_txd)); // R2
    AST_HELD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dma_tx_req | dma_rx_req)) |-> !sh_req); // R3
    AST_TX_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_tx_req & ~dma_tx_en) == '0); // R10
    AST_RX_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rx_req & ~dma_rx_en) == '0); // R10
    AST_ONE_HELD_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dma_tx_req) && $onehot0(dma_rx_req)); // R10
    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|(done_q & ~$past(done_q))) |-> $past(sh_ack)); // R7
endmodule

bind spi_tg_seq spi_tg_seq_chk #(.NGRP(NGRP), .DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .sh_req(sh_req), .sh_ack(sh_ack), .sh_txd(sh_txd),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
    .dma_tx_en(dma_tx_en), .dma_rx_en(dma_rx_en), .done_q(done_q)
);

// File: tb/spi_tg_seq_tb_top.sv
module spi_tg_seq_tb_top;
    localparam int NBUF = 128;
    localparam int DW   = 16;
    localparam int NGRP = 2;
    localparam int IW   = 7;
    localparam logic [15:0] KEY = 16'h5AC3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      bus_sel = '0;
    logic [IW-1:0]   bus_idx = '0;
    logic            bus_we = 1'b0, bus_re = 1'b0;
    logic [DW-1:0]   bus_wdata = '0, bus_rdata;
    logic [NGRP-1:0] grp_trig = '0;
    logic            sh_req, sh_ack = 1'b0, irq;
    logic [DW-1:0]   sh_txd, sh_rxd = '0;
    logic [NGRP-1:0] dma_tx_req, dma_rx_req;

    always #4 clk = ~clk;

    spi_tg_seq #(.NBUF(NBUF), .DW(DW), .NGRP(NGRP)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_idx(bus_idx),
        .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .grp_trig(grp_trig), .sh_req(sh_req), .sh_txd(sh_txd), .sh_ack(sh_ack),
        .sh_rxd(sh_rxd), .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] log_q [256];
    int log_n = 0;
    logic [15:0] shadow [NBUF];

    function automatic logic [15:0] exp_rx(logic [15:0] d);
        return d ^ KEY;
    endfunction

    function automatic logic [15:0] exp_vec(bit susp, int g);
        return (susp ? 16'h0010 : 16'h0000) | 16'(g + 1);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // shift-engine model: random latency, echoes word xor KEY
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            if (sh_ack) sh_ack = 1'b0;
            else if (sh_req && rst_n) begin
                if (dly == 0) begin
                    if (log_n < 256) log_q[log_n] = sh_txd;
                    log_n++;
                    sh_rxd = exp_rx(sh_txd);
                    sh_ack = 1'b1;
                    dly = int'($urandom % 3);
                end else dly--;
            end
        end
    end

    task automatic wr(logic [1:0] s, int idx, logic [15:0] d);
        @(negedge clk);
        bus_sel = s; bus_idx = IW'(idx); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] s, int idx, output logic [15:0] v);
        @(negedge clk);
        bus_sel = s; bus_idx = IW'(idx); bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        v = bus_rdata;
    endtask

    task automatic pulse(logic [NGRP-1:0] m);
        @(negedge clk);
        grp_trig = m;
        @(negedge clk);
        grp_trig = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_group(int g, int s, int e);
        wr(2'd3, g, 16'((e << 8) | s));
    endtask

    task automatic wait_done(int g);
        logic [15:0] v;
        for (int i = 0; i < 500; i++) begin
            rd(2'd3, 8, v);
            if (v[g]) break;
        end
    endtask

    task automatic load(int s, int e);
        for (int i = s; i <= e; i++) begin
            shadow[i] = 16'($urandom);
            wr(2'd0, i, shadow[i]);
            wr(2'd1, i, 16'h0000);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] old;
        void'($urandom(32'd20245));
        idle(5);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk("R1", "irq", int'(irq), 0);
        chk("R1", "sh_req", int'(sh_req), 0);
        chk("R1", "dma", int'({dma_tx_req, dma_rx_req}), 0);
        rd(2'd3, 8, v); chk("R1", "flags", int'(v), 0);
        rd(2'd3, 9, v); chk("R1", "vector", int'(v), 0);

        // R2 R7 R8: plain group 0 over buffers 0..7
        load(0, 7);
        set_group(0, 0, 7);
        log_n = 0;
        pulse(2'b01);
        wait_done(0);
        chk("R2", "word count", log_n, 8);
        for (int i = 0; i < 8; i++) chk("R2", "tx order", int'(log_q[i]), int'(shadow[i]));
        rd(2'd1, 2, v);
        chk("R2", "rx full set", int'(v[9]), 1);
        chk("R2", "tx full cleared", int'(v[8]), 0);
        for (int i = 0; i < 8; i++) begin
            rd(2'd2, i, v); chk("R2", "rx word", int'(v), int'(exp_rx(shadow[i])));
        end
        rd(2'd1, 2, v); chk("R2", "rx full drained", int'(v[9]), 0);
        rd(2'd3, 8, v); chk("R7", "done flag", int'(v[0]), 1);
        rd(2'd3, 9, v); chk("R8", "vector done g0", int'(v), int'(exp_vec(0, 0)));
        rd(2'd3, 9, v); chk("R8", "vector after read", int'(v), 0);

        // R11: retrigger while running is ignored
        log_n = 0;
        pulse(2'b01);
        idle(2);
        pulse(2'b01);
        wait_done(0);
        idle(30);
        chk("R11", "single pass", log_n, 8);
        wr(2'd3, 8, 16'h0001);
        rd(2'd3, 8, v); chk("R9", "w1c done", int'(v), 0);

        // R4 R10: mode 6 on buffer 3, its rx slot still full
        wr(2'd1, 3, 16'h0006);
        log_n = 0;
        pulse(2'b01);
        idle(40);
        chk("R4", "held at buffer 3", log_n, 3);
        rd(2'd3, 8, v); chk("R6", "suspend g0", int'(v[8]), 1);
        chk("R10", "rx dma disabled", int'(dma_rx_req), 0);
        wr(2'd3, 10, 16'h0100);
        chk("R10", "rx dma enabled", int'(dma_rx_req), 1);
        rd(2'd2, 3, v); chk("R4", "drained word", int'(v), int'(exp_rx(shadow[3])));
        wait_done(0);
        chk("R4", "released", log_n, 8);
        chk("R10", "rx dma idle", int'(dma_rx_req), 0);
        wr(2'd3, 8, 16'h0101);

        // R5: mode 7 on buffer 5 needs refill and drain
        wr(2'd1, 3, 16'h0000);
        wr(2'd1, 5, 16'h0007);
        log_n = 0;
        pulse(2'b01);
        idle(40);
        chk("R5", "held at buffer 5", log_n, 5);
        old = shadow[5];
        shadow[5] = 16'($urandom);
        wr(2'd0, 5, shadow[5]);
        idle(20);
        chk("R5", "refill alone holds", log_n, 5);
        rd(2'd2, 5, v); chk("R5", "old rx word", int'(v), int'(exp_rx(old)));
        wait_done(0);
        chk("R5", "released", log_n, 8);
        chk("R5", "new word sent", int'(log_q[5]), int'(shadow[5]));
        wr(2'd1, 5, 16'h0000);
        wr(2'd3, 8, 16'h0100);
        wr(2'd3, 10, 16'h0000);

        // R3 R6 R8 R10: group 1 held by mode 5 while g0 done is pending
        shadow[20] = 16'($urandom); wr(2'd0, 20, shadow[20]);
        shadow[22] = 16'($urandom); wr(2'd0, 22, shadow[22]);
        shadow[23] = 16'($urandom); wr(2'd0, 23, shadow[23]);
        wr(2'd1, 21, 16'h0005);
        set_group(1, 20, 23);
        log_n = 0;
        pulse(2'b10);
        idle(40);
        chk("R3", "held at buffer 21", log_n, 1);
        chk("R10", "tx dma disabled", int'(dma_tx_req), 0);
        rd(2'd3, 8, v); chk("R6", "suspend g1", int'(v[9]), 1);
        chk("R6", "irq", int'(irq), 1);
        wr(2'd3, 10, 16'h0002);
        chk("R10", "tx dma enabled", int'(dma_tx_req), 2);
        rd(2'd3, 9, v); chk("R8", "suspend beats done", int'(v), int'(exp_vec(1, 1)));
        idle(2);
        rd(2'd3, 8, v); chk("R6", "suspend re-raised", int'(v[9]), 1);
        shadow[21] = 16'($urandom);
        wr(2'd0, 21, shadow[21]);
        wait_done(1);
        chk("R3", "released", log_n, 4);
        for (int i = 0; i < 4; i++) chk("R3", "tx order", int'(log_q[i]), int'(shadow[20 + i]));
        chk("R10", "tx dma idle", int'(dma_tx_req), 0);
        rd(2'd3, 9, v); chk("R6", "vector clears suspend", int'(v), int'(exp_vec(1, 1)));
        rd(2'd3, 9, v); chk("R8", "lower group done first", int'(v), int'(exp_vec(0, 0)));
        rd(2'd3, 9, v); chk("R8", "group 1 done", int'(v), int'(exp_vec(0, 1)));
        rd(2'd3, 9, v); chk("R8", "vector empty", int'(v), 0);
        wr(2'd1, 21, 16'h0000);
        wr(2'd3, 10, 16'h0000);

        // R12: both groups armed in the same cycle
        load(0, 3);
        load(40, 42);
        set_group(0, 0, 3);
        set_group(1, 40, 42);
        log_n = 0;
        pulse(2'b11);
        wait_done(0);
        wait_done(1);
        chk("R12", "total words", log_n, 7);
        for (int i = 0; i < 4; i++) chk("R12", "g0 first", int'(log_q[i]), int'(shadow[i]));
        for (int i = 0; i < 3; i++) chk("R12", "g1 after", int'(log_q[4 + i]), int'(shadow[40 + i]));
        wr(2'd3, 8, 16'h0003);

        // R2 R7 random windows
        for (int it = 0; it < 6; it++) begin
            int g = int'($urandom % 2);
            int s = int'($urandom % 120);
            int len = (it == 0) ? 1 : 1 + int'($urandom % 8);
            load(s, s + len - 1);
            set_group(g, s, s + len - 1);
            log_n = 0;
            pulse(NGRP'(1 << g));
            wait_done(g);
            chk("R7", "random count", log_n, len);
            for (int i = 0; i < len; i++) begin
                chk("R2", "random tx", int'(log_q[i]), int'(shadow[s + i]));
                rd(2'd2, s + i, v); chk("R2", "random rx", int'(v), int'(exp_rx(shadow[s + i])));
            end
            wr(2'd3, 8, 16'(1 << g));
            rd(2'd3, 8, v); chk("R9", "random w1c", int'(v), 0);
        end

        summary();
        $finish;
    end
endmodule